// File: doc/BRIEF.md
# Ethernet PHY Link/Activity LED Controller

This block drives the single link indicator of a 10/100 Ethernet PHY. The pad it drives also serves as a configuration strap at power-up. While reset is held the pad driver stays off, and the block keeps capturing the level that the board resistor sets on the pad. When reset is released that level is frozen and fixes the LED polarity. A low strap gives an active-high LED and a high strap gives an active-low LED. Only then is the driver enabled.

Link comes from one of two sources. At 100 Mb/s it follows the signal-detect input. At 10 Mb/s the block qualifies link itself: it needs a run of consecutive normal link pulses with spacing inside a window, or one valid received packet. A loss timer drops the 10 Mb/s link when pulses and packets stop.

A register bit selects one of two display modes. Steady mode shows link only. Blink mode also shows transmit or receive activity by blinking the LED. Activity is stretched so that a single short frame still produces a visible blink. A second register can take over the LED directly. Both registers are loaded through a simple write-only port.

Top module: `eth_link_led`

## Requirements
- R1: While `rst_n` is low, `led_pad_oe` and `led_pad_out` are 0. `led_pad_oe` becomes 1 within 4 clocks after `rst_n` rises and stays 1.
- R2: The `led_pad_in` level present while reset is held sets the polarity. A 0 makes the pad drive 1 for a lit LED. A 1 makes the pad drive 0 for a lit LED.
- R3: The mode bit is bit 5 of the register at address 0x19. A value of 1 selects steady mode and 0 selects blink mode. The bit resets to 1.
- R4: In steady mode the LED is lit exactly while link is up, whatever the activity inputs do.
- R5: In blink mode the LED is dark without link and lit with link and no activity. With link and continuous activity, it alternates lit and dark in phases of `BLINK_HALF` clocks.
- R6: A single-cycle `tx_act` or `rx_act` strobe keeps activity present for 2×`BLINK_HALF` clocks. In blink mode this gives at least one dark interval.
- R7: With `speed_100` = 1, link follows `sig_det`, delayed by one register.
- R8: With `speed_100` = 0, link is declared on the `NLP_NEED`-th consecutive link pulse. A pulse is consecutive when it comes `NLP_GAP_MIN` to `NLP_GAP_MAX` clocks after the previous one. Any other spacing restarts the run at one.
- R9: With `speed_100` = 0, a `rx_pkt_ok` strobe declares link at once.
- R10: A 10 Mb/s link drops `LINK_LOSS` clocks after the last link pulse or valid packet.
- R11: In the register at address 0x18, bit 1 enables direct control and bit 0 is the LED state to show. While bit 1 is set, the LED shows bit 0 and ignores link, mode and activity.
- R12: Writes to any address other than 0x18 and 0x19 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_100 | input | 1 | 1 = 100 Mb/s link source, 0 = 10 Mb/s qualifier |
| sig_det | input | 1 | 100 Mb/s signal detect |
| nlp_pulse | input | 1 | One-clock strobe per normal link pulse |
| rx_pkt_ok | input | 1 | One-clock strobe per valid 10 Mb/s packet |
| tx_act | input | 1 | Transmit activity |
| rx_act | input | 1 | Receive activity |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| led_pad_in | input | 1 | Pad level, read as strap during reset |
| led_pad_out | output | 1 | Pad drive value, polarity applied |
| led_pad_oe | output | 1 | Pad driver enable |

## Verification
The assertions assume that `rst_n` starts low at time zero. They also assume that `nlp_pulse` and `rx_pkt_ok` are one-clock strobes, so that a rising 10 Mb/s link can be traced to an event in the previous cycle. The bench holds `led_pad_in` steady for the whole of each reset, because a late strap change would be captured. It drives every strobe for exactly one clock at the falling edge. Link pulse spacing is placed deliberately inside or outside the qualification window, never on its edge by accident.

// File: rtl/eth_led_pkg.sv
package eth_led_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam logic [ADDR_W-1:0] CTRL_ADDR   = 5'h19;
  localparam logic [ADDR_W-1:0] DIRECT_ADDR = 5'h18;
  localparam int MODE_BIT   = 5;
  localparam int DIR_VAL_BIT = 0;
  localparam int DIR_EN_BIT  = 1;

  typedef enum logic {
    MODE_BLINK  = 1'b0,
    MODE_STEADY = 1'b1
  } led_mode_e;
endpackage

// File: rtl/eth_led_rst_sync.sv
module eth_led_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/eth_led_regs.sv
module eth_led_regs
  import eth_led_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output led_mode_e         mode_o,
  output logic              ovr_en_o,
  output logic              ovr_val_o
);
  led_mode_e mode_q, mode_n;
  logic      en_q, en_n, val_q, val_n;
  logic      ctrl_we, dir_we;

  always_comb begin
    ctrl_we = wr_i && (addr_i == CTRL_ADDR);
    dir_we  = wr_i && (addr_i == DIRECT_ADDR);
    mode_n  = mode_q;
    en_n    = en_q;
    val_n   = val_q;
    if (ctrl_we) mode_n = led_mode_e'(wdata_i[MODE_BIT]);
    if (dir_we) begin
      en_n  = wdata_i[DIR_EN_BIT];
      val_n = wdata_i[DIR_VAL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_STEADY;
      en_q   <= 1'b0;
      val_q  <= 1'b0;
    end else begin
      if (ctrl_we) mode_q <= mode_n;
      if (dir_we) begin
        en_q  <= en_n;
        val_q <= val_n;
      end
    end
  end

  assign mode_o    = mode_q;
  assign ovr_en_o  = en_q;
  assign ovr_val_o = val_q;
endmodule

// File: rtl/eth_led_link10.sv
module eth_led_link10 #(
  parameter int GAP_MIN = 200000,
  parameter int GAP_MAX = 600000,
  parameter int LOSS    = 2500000,
  parameter int NEED    = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic nlp_i,
  input  logic pkt_i,
  output logic link_o
);
  localparam int GAP_W  = $clog2(GAP_MAX + 2);
  localparam int LOSS_W = $clog2(LOSS + 1);
  localparam int CNT_W  = $clog2(NEED + 1);
  localparam logic [GAP_W-1:0]  GAP_LO  = GAP_W'(GAP_MIN);
  localparam logic [GAP_W-1:0]  GAP_HI  = GAP_W'(GAP_MAX);
  localparam logic [GAP_W-1:0]  GAP_SAT = GAP_W'(GAP_MAX + 1);
  localparam logic [LOSS_W-1:0] LOSS_END = LOSS_W'(LOSS - 1);
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(NEED);

  logic [GAP_W-1:0]  gap_q, gap_n;
  logic [LOSS_W-1:0] loss_q, loss_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              link_q, link_n;
  logic              in_win;

  always_comb begin
    gap_n  = gap_q;
    loss_n = loss_q;
    cnt_n  = cnt_q;
    link_n = link_q;
    in_win = (gap_q >= GAP_LO) && (gap_q <= GAP_HI);
    if (clr_i) begin
      gap_n  = '0;
      loss_n = '0;
      cnt_n  = '0;
      link_n = 1'b0;
    end else begin
      if (gap_q != '0 && gap_q != GAP_SAT) gap_n = gap_q + 1'b1;
      if (nlp_i) begin
        gap_n = GAP_W'(1);
        if (in_win) cnt_n = (cnt_q == CNT_FULL) ? CNT_FULL : cnt_q + 1'b1;
        else        cnt_n = CNT_W'(1);
      end
      if (nlp_i || pkt_i) begin
        loss_n = '0;
      end else if (link_q) begin
        if (loss_q == LOSS_END) begin
          link_n = 1'b0;
          loss_n = '0;
          cnt_n  = '0;
        end else begin
          loss_n = loss_q + 1'b1;
        end
      end
      if (pkt_i || (nlp_i && cnt_n == CNT_FULL)) link_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      loss_q <= '0;
      cnt_q  <= '0;
      link_q <= 1'b0;
    end else begin
      gap_q  <= gap_n;
      loss_q <= loss_n;
      cnt_q  <= cnt_n;
      link_q <= link_n;
    end
  end

  assign link_o = link_q;
endmodule

// File: rtl/eth_led_blink.sv
module eth_led_blink #(
  parameter int HALF = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  output logic active_o,
  output logic phase_o
);
  localparam int DIV_W = $clog2(HALF);
  localparam int STR_W = $clog2(2 * HALF + 1);
  localparam logic [DIV_W-1:0] DIV_END  = DIV_W'(HALF - 1);
  localparam logic [STR_W-1:0] STR_LOAD = STR_W'(2 * HALF);

  logic [DIV_W-1:0] div_q, div_n;
  logic [STR_W-1:0] str_q, str_n;
  logic             ph_q, ph_n;
  logic             wrap;

  always_comb begin
    wrap  = (div_q == DIV_END);
    div_n = wrap ? '0 : div_q + 1'b1;
    ph_n  = wrap ? ~ph_q : ph_q;
    if (act_i)             str_n = STR_LOAD;
    else if (str_q != '0)  str_n = str_q - 1'b1;
    else                   str_n = str_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ph_q  <= 1'b0;
      str_q <= '0;
    end else begin
      div_q <= div_n;
      ph_q  <= ph_n;
      str_q <= str_n;
    end
  end

  assign active_o = (str_q != '0);
  assign phase_o  = ph_q;
endmodule

// File: rtl/eth_link_led.sv
module eth_link_led
  import eth_led_pkg::*;
#(
  parameter int NLP_GAP_MIN = 200000,
  parameter int NLP_GAP_MAX = 600000,
  parameter int LINK_LOSS   = 2500000,
  parameter int NLP_NEED    = 7,
  parameter int BLINK_HALF  = 1250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              speed_100,
  input  logic              sig_det,
  input  logic              nlp_pulse,
  input  logic              rx_pkt_ok,
  input  logic              tx_act,
  input  logic              rx_act,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              led_pad_in,
  output logic              led_pad_out,
  output logic              led_pad_oe
);
  logic      rst_sync_n;
  logic      strap_q;
  logic      oe_q;
  logic      sig_q;
  logic      link10, link, active, phase;
  logic      ovr_en, ovr_val;
  led_mode_e mode;
  logic      steady;
  logic      led_on;
  logic      out_q, out_n;

  eth_led_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  eth_led_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .mode_o(mode), .ovr_en_o(ovr_en), .ovr_val_o(ovr_val)
  );

  eth_led_link10 #(
    .GAP_MIN(NLP_GAP_MIN), .GAP_MAX(NLP_GAP_MAX), .LOSS(LINK_LOSS), .NEED(NLP_NEED)
  ) u_link10 (
    .clk(clk), .rst_n(rst_sync_n), .clr_i(speed_100), .nlp_i(nlp_pulse),
    .pkt_i(rx_pkt_ok), .link_o(link10)
  );

  eth_led_blink #(.HALF(BLINK_HALF)) u_blink (
    .clk(clk), .rst_n(rst_sync_n), .act_i(tx_act | rx_act),
    .active_o(active), .phase_o(phase)
  );

  // Strap capture: clock enable is the held reset, no reset on the register.
  always_ff @(posedge clk) begin
    if (!rst_sync_n) strap_q <= led_pad_in;
  end

  always_comb begin
    steady = (mode == MODE_STEADY);
    link   = speed_100 ? sig_q : link10;
    if (ovr_en)      led_on = ovr_val;
    else if (steady) led_on = link;
    else             led_on = link & (~active | phase);
    out_n = led_on ^ strap_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      oe_q  <= 1'b0;
      sig_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      oe_q  <= 1'b1;
      sig_q <= sig_det;
      out_q <= out_n;
    end
  end

  assign led_pad_out = out_q;
  assign led_pad_oe  = oe_q;
endmodule

// File: rtl/eth_link_led_chk.sv
module eth_link_led_chk (
  input logic clk,
  input logic rst_n,
  input logic led_pad_oe,
  input logic led_pad_out,
  input logic strap_q,
  input logic ovr_en,
  input logic ovr_val,
  input logic steady,
  input logic link,
  input logic active,
  input logic link10,
  input logic nlp_pulse,
  input logic rx_pkt_ok
);
  p_oe_off_in_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (!led_pad_oe && !led_pad_out));

  p_oe_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(led_pad_oe) |-> led_pad_oe);

  p_strap_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (led_pad_oe && $past(led_pad_oe)) |-> $stable(strap_q));

  p_steady_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (led_pad_oe && $past(led_pad_oe) && $past(steady && !link && !ovr_en))
      |-> (led_pad_out == strap_q));

  p_quiet_lit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (led_pad_oe && $past(led_pad_oe) && $past(link && !active && !ovr_en))
      |-> (led_pad_out == !strap_q));

  p_link10_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link10) |-> $past(nlp_pulse || rx_pkt_ok));

  p_direct_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (led_pad_oe && $past(led_pad_oe) && $past(ovr_en))
      |-> (led_pad_out == ($past(ovr_val) ^ strap_q)));
endmodule

bind eth_link_led eth_link_led_chk u_chk (
  .clk(clk), .rst_n(rst_n), .led_pad_oe(led_pad_oe), .led_pad_out(led_pad_out),
  .strap_q(strap_q), .ovr_en(ovr_en), .ovr_val(ovr_val), .steady(steady),
  .link(link), .active(active), .link10(link10), .nlp_pulse(nlp_pulse),
  .rx_pkt_ok(rx_pkt_ok)
);

// File: tb/tb_eth_link_led.sv
`timescale 1ns/1ps
module tb_eth_link_led;
  localparam int GMIN = 8;
  localparam int GMAX = 24;
  localparam int LOSS = 100;
  localparam int NEED = 7;
  localparam int HALF = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic speed_100 = 1'b1, sig_det = 1'b0, nlp_pulse = 1'b0, rx_pkt_ok = 1'b0;
  logic tx_act = 1'b0, rx_act = 1'b0, reg_wr = 1'b0, led_pad_in = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic led_pad_out, led_pad_oe;
  logic strap = 1'b0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  eth_link_led #(
    .NLP_GAP_MIN(GMIN), .NLP_GAP_MAX(GMAX), .LINK_LOSS(LOSS),
    .NLP_NEED(NEED), .BLINK_HALF(HALF)
  ) dut (
    .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .sig_det(sig_det),
    .nlp_pulse(nlp_pulse), .rx_pkt_ok(rx_pkt_ok), .tx_act(tx_act), .rx_act(rx_act),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .led_pad_in(led_pad_in), .led_pad_out(led_pad_out), .led_pad_oe(led_pad_oe)
  );

  // {steady_mode, sig_det, direct_en, direct_val, expected_lit}
  localparam logic [4:0] VEC [8] = '{
    5'b1_1_0_0_1, 5'b1_0_0_0_0, 5'b0_1_0_0_1, 5'b0_0_0_0_0,
    5'b1_0_1_1_1, 5'b1_1_1_0_0, 5'b0_1_1_0_0, 5'b0_0_1_1_1
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic nlp_gap(input int gap);
    cyc(gap - 1);
    nlp_pulse = 1'b1;
    @(negedge clk);
    nlp_pulse = 1'b0;
  endtask

  // lit state as seen on the pad for the current strap
  function automatic logic lit();
    return led_pad_out ^ strap;
  endfunction

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0; led_pad_in = s; strap = s;
    cyc(4);
    check("R1 oe in reset", led_pad_oe, 1'b0);
    check("R1 out in reset", led_pad_out, 1'b0);
    rst_n = 1'b1;
    cyc(4);
    check("R1 oe after reset", led_pad_oe, 1'b1);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      report();
    end
  end

  initial begin
    int offs;
    do_reset(1'b0);

    // R3: reset mode is steady; activity must not blink the LED
    sig_det = 1'b1; tx_act = 1'b1;
    cyc(4);
    offs = 0;
    for (int i = 0; i < 4 * HALF; i++) begin cyc(1); if (!lit()) offs++; end
    check_int("R3 steady after reset", offs, 0);
    tx_act = 1'b0;
    cyc(2 * HALF + 4);

    // vector table: R4/R5/R7 without override, R11 with override
    for (int v = 0; v < 8; v++) begin
      wr(5'h19, VEC[v][4] ? 16'h0020 : 16'h0000);
      wr(5'h18, {14'd0, VEC[v][2], VEC[v][1]});
      sig_det = VEC[v][3];
      cyc(4);
      check(VEC[v][2] ? "R11 direct control" : "R7 link follows sig_det",
            lit(), VEC[v][0]);
    end
    wr(5'h18, 16'h0000);

    // R12: stray addresses change nothing
    wr(5'h19, 16'h0020);
    sig_det = 1'b0;
    wr(5'h1A, 16'hFFFF);
    wr(5'h17, 16'hFFFF);
    wr(5'h00, 16'hFFFF);
    cyc(4);
    check("R12 stray writes", lit(), 1'b0);
    sig_det = 1'b1; tx_act = 1'b1;
    cyc(4);
    offs = 0;
    for (int i = 0; i < 4 * HALF; i++) begin cyc(1); if (!lit()) offs++; end
    check_int("R12 mode untouched", offs, 0);

    // R5: blink mode, continuous activity -> half of the time dark
    wr(5'h19, 16'h0000);
    cyc(4);
    offs = 0;
    for (int i = 0; i < 4 * HALF; i++) begin cyc(1); if (!lit()) offs++; end
    check_int("R5 blink duty", offs, 2 * HALF);
    tx_act = 1'b0;
    cyc(2 * HALF + 4);
    offs = 0;
    for (int i = 0; i < 4 * HALF; i++) begin cyc(1); if (!lit()) offs++; end
    check_int("R5 idle lit", offs, 0);

    // R6: single-cycle strobe still blinks
    rx_act = 1'b1; cyc(1); rx_act = 1'b0;
    offs = 0;
    for (int i = 0; i < 2 * HALF + 4; i++) begin cyc(1); if (!lit()) offs++; end
    check("R6 stretched blink", offs > 0, 1'b1);
    cyc(HALF);
    check("R6 back to lit", lit(), 1'b1);

    // R8: 10 Mb/s link pulse qualification, steady mode
    wr(5'h19, 16'h0020);
    speed_100 = 1'b0;
    cyc(3);
    check("R8 no link at start", lit(), 1'b0);
    nlp_gap(1);
    for (int i = 0; i < NEED - 2; i++) nlp_gap(16);
    cyc(3);
    check("R8 one pulse short", lit(), 1'b0);
    nlp_gap(37);
    for (int i = 0; i < NEED - 2; i++) nlp_gap(16);
    cyc(3);
    check("R8 out of window restarts run", lit(), 1'b0);
    nlp_gap(13);
    cyc(3);
    check("R8 link on full run", lit(), 1'b1);

    // R10: loss timer
    cyc(LOSS - 30);
    check("R10 still up before timeout", lit(), 1'b1);
    cyc(40);
    check("R10 dropped after timeout", lit(), 1'b0);

    // R9: one packet declares link, then loss again
    @(negedge clk); rx_pkt_ok = 1'b1; @(negedge clk); rx_pkt_ok = 1'b0;
    cyc(3);
    check("R9 packet link", lit(), 1'b1);
    cyc(LOSS + 10);
    check("R10 packet link expires", lit(), 1'b0);

    // R2: high strap -> active-low drive
    speed_100 = 1'b1; sig_det = 1'b1;
    do_reset(1'b1);
    check("R2 lit drives low", led_pad_out, 1'b0);
    sig_det = 1'b0;
    cyc(4);
    check("R2 dark drives high", led_pad_out, 1'b1);
    do_reset(1'b0);
    check("R2 low strap dark drives low", led_pad_out, 1'b0);

    done = 1'b1;
    report();
  end
endmodule